// File: doc/BRIEF.md
# Batched Bulk-Memory Cell FIFO

This block is a deep first-in first-out queue for fixed-width cells. A large bulk store gives it most of its depth. The store is slow to open but fast once a burst is running. Two small fast ring buffers sit around the store and hide its latency:

- **Tail ring:** collects arriving cells and hands them to the store only as whole bursts of `BURST` cells. Each burst fills one row of the store at consecutive addresses.
- **Head ring:** receives whole bursts read back from the store. It presents one cell per cycle to the consumer.

When the store holds nothing and no store burst is in progress, cells skip the store. They move straight from the tail ring to the head ring, one per cycle. This keeps latency low when the queue is short.

Both ends use a valid/ready handshake. A cell moves on a rising clock edge where valid and ready are both 1. Cells enter on `enq_cell` and leave on `deq_cell`. The bulk store's access latency is a fixed parameter, `BULK_LAT`. Every burst waits that many cycles and then moves one cell per cycle.

Top module: `cell_bulk_fifo`

## Requirements
- R1: After reset, `enq_ready` is 1 and `deq_valid` is 0. Any cells stored before the reset are discarded, so the first cell offered after reset is the first cell accepted after reset.
- R2: A cell is accepted on a rising edge where `enq_valid` and `enq_ready` are both 1, and taken on a rising edge where `deq_valid` and `deq_ready` are both 1. Cells leave in exactly the order they were accepted, with none lost and none repeated.
- R3: `deq_valid` is 1 exactly when a cell is waiting. After the last stored cell is taken, `deq_valid` is 0 in the following cycle.
- R4: With dequeue held off, the block accepts exactly 2*BUF_CELLS + BULK_ROWS*BURST cells (48 with default parameters). After that, `enq_ready` stays 0.
- R5: Suppose the block is empty and the bulk store is idle. A cell accepted at one rising edge is then not yet offered after that edge. It is offered on `deq_cell`, with `deq_valid` 1, after the next rising edge.
- R6: The bulk store is accessed only in bursts of `BURST` cells at consecutive addresses of one row. Each burst starts after a wait of `BULK_LAT` cycles. With default parameters, a full block drains within 150 cycles when `deq_ready` is held at 1.
- R7: While `deq_valid` is 1 and `deq_ready` is 0, `deq_valid` stays 1 and `deq_cell` holds its value.
- R8: Driving `enq_valid` while `enq_ready` is 0 has no effect. No cell is accepted, and draining afterwards yields no extra cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Producer offers a cell |
| enq_ready | output | 1 | Block can accept a cell (tail ring not full) |
| enq_cell | input | CELL_W | Cell being offered |
| deq_valid | output | 1 | A cell is available at the head |
| deq_ready | input | 1 | Consumer takes the cell |
| deq_cell | output | CELL_W | Oldest stored cell |

## Verification
The hardest situation to reach is the one where cells sit in all three places at once. In that state the tail ring holds a partial burst, the bulk store holds several rows, and the head ring is nearly full. Order then depends on the bypass path staying shut until the store has fully drained.

The stimulus reaches this state by holding `deq_ready` low long enough to fill the head ring and then push rows into the store. It then releases the consumer at a reduced or irregular rate. During the release, new cells keep arriving in counts that are not multiples of the burst size. A full-capacity run with a stalled consumer covers the exact fill count, the ignored offers, and the drain time.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_WWAIT = 3'd1,
    BK_WBEAT = 3'd2,
    BK_RWAIT = 3'd3,
    BK_RBEAT = 3'd4
  } bk_state_e;
endpackage

// File: rtl/cbf_ring.sv
// Small ring buffer used for both the tail and head caches.
module cbf_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_cell,
  input  logic                       pop,
  output logic [W-1:0]               pop_cell,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) slots[wr_idx] <= push_cell;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      if (pop)  rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pop_cell = slots[rd_idx];
  assign count    = cnt_q;
  assign full     = (cnt_q == FULL_CNT);
  assign empty    = (cnt_q == '0);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));
endmodule

// File: rtl/cbf_bulk.sv
// Bulk store model: fixed access wait, then one cell per cycle within a row.
module cbf_bulk
  import cbf_pkg::*;
#(
  parameter int W    = 16,
  parameter int B    = 4,
  parameter int ROWS = 8,
  parameter int LAT  = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_wr,
  input  logic         req_rd,
  input  logic [W-1:0] wr_cell,
  output logic         wr_beat,
  output logic         rd_vld,
  output logic [W-1:0] rd_cell,
  output logic         idle,
  output logic         is_empty,
  output logic         has_row,
  output logic         has_room
);
  localparam int CELLS = B * ROWS;
  localparam int AW = $clog2(CELLS);
  localparam int BW = $clog2(B);
  localparam int RW = $clog2(ROWS);
  localparam int LW = $clog2(CELLS + 1);
  localparam int TW = $clog2(LAT + 1);
  localparam logic [BW-1:0] BEAT_LAST = BW'(B - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(LAT - 1);
  localparam logic [AW-1:0] B_A       = AW'(B);

  bk_state_e     state;
  logic [TW-1:0] wait_q;
  logic [BW-1:0] beat_q;
  logic [RW-1:0] wr_row, rd_row;
  logic [LW-1:0] level;
  logic [W-1:0]  store [CELLS];
  logic [W-1:0]  rd_q;
  logic          rd_vld_q;
  logic [AW-1:0] wr_addr, rd_addr;

  assign wr_addr = AW'(wr_row) * B_A + AW'(beat_q);
  assign rd_addr = AW'(rd_row) * B_A + AW'(beat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= BK_IDLE;
      wait_q <= '0;
      beat_q <= '0;
      wr_row <= '0;
      rd_row <= '0;
      level  <= '0;
    end else begin
      case (state)
        BK_IDLE: begin
          wait_q <= '0;
          beat_q <= '0;
          if (req_wr)      state <= BK_WWAIT;
          else if (req_rd) state <= BK_RWAIT;
        end
        BK_WWAIT, BK_RWAIT: begin
          if (wait_q == WAIT_LAST) begin
            state  <= (state == BK_WWAIT) ? BK_WBEAT : BK_RBEAT;
            beat_q <= '0;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        BK_WBEAT: begin
          beat_q <= beat_q + 1'b1;
          level  <= level + 1'b1;
          if (beat_q == BEAT_LAST) begin
            state  <= BK_IDLE;
            wr_row <= (wr_row == ROW_LAST) ? '0 : wr_row + 1'b1;
          end
        end
        BK_RBEAT: begin
          beat_q <= beat_q + 1'b1;
          level  <= level - 1'b1;
          if (beat_q == BEAT_LAST) begin
            state  <= BK_IDLE;
            rd_row <= (rd_row == ROW_LAST) ? '0 : rd_row + 1'b1;
          end
        end
        default: state <= BK_IDLE;
      endcase
    end
  end

  // Memory kept free of reset so it maps onto block RAM with a registered read.
  always_ff @(posedge clk) begin
    if (state == BK_WBEAT) store[wr_addr] <= wr_cell;
    rd_q <= store[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= (state == BK_RBEAT);
  end

  assign wr_beat  = (state == BK_WBEAT);
  assign rd_vld   = rd_vld_q;
  assign rd_cell  = rd_q;
  assign idle     = (state == BK_IDLE) && !rd_vld_q;
  assign is_empty = (level == '0);
  assign has_row  = (level >= LW'(B));
  assign has_room = (level <= LW'(CELLS - B));

  // Checker-side count of wait cycles before each burst.
  logic [TW:0] wait_seen;
  always_ff @(posedge clk) begin
    if (rst) wait_seen <= '0;
    else if (state == BK_WWAIT || state == BK_RWAIT) wait_seen <= wait_seen + 1'b1;
    else wait_seen <= '0;
  end

  p_req_only_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (req_wr || req_rd) |-> idle);
  p_wbeat_step_r6: assert property (@(posedge clk) disable iff (rst)
    (state == BK_WBEAT && beat_q != BEAT_LAST) |=>
      (state == BK_WBEAT && beat_q == BW'($past(beat_q) + 1'b1)));
  p_rbeat_step_r6: assert property (@(posedge clk) disable iff (rst)
    (state == BK_RBEAT && beat_q != BEAT_LAST) |=>
      (state == BK_RBEAT && beat_q == BW'($past(beat_q) + 1'b1)));
  p_wait_len_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == BK_WBEAT || state == BK_RBEAT) && beat_q == '0) |->
      (wait_seen == (TW + 1)'(LAT)));
  p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(CELLS));
endmodule

// File: rtl/cbf_sched.sv
// Decides each cycle between bypass, a store write burst and a store read burst.
module cbf_sched #(
  parameter int B          = 4,
  parameter int TAIL_DEPTH = 8,
  parameter int HEAD_DEPTH = 8
) (
  input  logic [$clog2(TAIL_DEPTH+1)-1:0] tail_cnt,
  input  logic [$clog2(HEAD_DEPTH+1)-1:0] head_cnt,
  input  logic                            tail_empty,
  input  logic                            head_full,
  input  logic                            bk_idle,
  input  logic                            bk_empty,
  input  logic                            bk_has_row,
  input  logic                            bk_has_room,
  output logic                            bypass,
  output logic                            req_wr,
  output logic                            req_rd
);
  localparam int TCW = $clog2(TAIL_DEPTH + 1);
  localparam int HCW = $clog2(HEAD_DEPTH + 1);
  localparam logic [TCW-1:0] T_BURST  = TCW'(B);
  localparam logic [HCW-1:0] H_BURST  = HCW'(B);
  localparam logic [HCW-1:0] H_ROOMAX = HCW'(HEAD_DEPTH - B);

  logic quiet, can_wr, can_rd;

  always_comb begin
    quiet  = bk_idle && bk_empty;
    bypass = quiet && !tail_empty && !head_full;
    can_wr = bk_idle && !bypass && (tail_cnt >= T_BURST) && bk_has_room;
    can_rd = bk_idle && bk_has_row && (head_cnt <= H_ROOMAX);
    req_rd = can_rd && ((head_cnt < H_BURST) || !can_wr);
    req_wr = can_wr && !req_rd;
  end
endmodule

// File: rtl/cell_bulk_fifo.sv
module cell_bulk_fifo
  import cbf_pkg::*;
#(
  parameter int CELL_W    = 16,
  parameter int BURST     = 4,
  parameter int BUF_CELLS = 2 * BURST,
  parameter int BULK_ROWS = 8,
  parameter int BULK_LAT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [CELL_W-1:0] enq_cell,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [CELL_W-1:0] deq_cell
);
  localparam int CW = $clog2(BUF_CELLS + 1);

  logic [CW-1:0]     tail_cnt, head_cnt;
  logic              tail_full, tail_empty, head_full, head_empty;
  logic              tail_push, tail_pop, head_push, head_pop;
  logic [CELL_W-1:0] tail_out, head_in, bk_rd_cell;
  logic              bypass, req_wr, req_rd;
  logic              bk_wr_beat, bk_rd_vld, bk_idle, bk_empty, bk_has_row, bk_has_room;

  assign enq_ready = !tail_full;
  assign deq_valid = !head_empty;
  assign tail_push = enq_valid && !tail_full;
  assign tail_pop  = bypass || bk_wr_beat;
  assign head_push = bypass || bk_rd_vld;
  assign head_pop  = deq_ready && !head_empty;
  assign head_in   = bypass ? tail_out : bk_rd_cell;

  cbf_ring #(.W(CELL_W), .DEPTH(BUF_CELLS)) u_tail (
    .clk(clk), .rst(rst),
    .push(tail_push), .push_cell(enq_cell),
    .pop(tail_pop), .pop_cell(tail_out),
    .count(tail_cnt), .full(tail_full), .empty(tail_empty)
  );

  cbf_bulk #(.W(CELL_W), .B(BURST), .ROWS(BULK_ROWS), .LAT(BULK_LAT)) u_bulk (
    .clk(clk), .rst(rst),
    .req_wr(req_wr), .req_rd(req_rd), .wr_cell(tail_out),
    .wr_beat(bk_wr_beat), .rd_vld(bk_rd_vld), .rd_cell(bk_rd_cell),
    .idle(bk_idle), .is_empty(bk_empty), .has_row(bk_has_row), .has_room(bk_has_room)
  );

  cbf_sched #(.B(BURST), .TAIL_DEPTH(BUF_CELLS), .HEAD_DEPTH(BUF_CELLS)) u_sched (
    .tail_cnt(tail_cnt), .head_cnt(head_cnt),
    .tail_empty(tail_empty), .head_full(head_full),
    .bk_idle(bk_idle), .bk_empty(bk_empty),
    .bk_has_row(bk_has_row), .bk_has_room(bk_has_room),
    .bypass(bypass), .req_wr(req_wr), .req_rd(req_rd)
  );

  cbf_ring #(.W(CELL_W), .DEPTH(BUF_CELLS)) u_head (
    .clk(clk), .rst(rst),
    .push(head_push), .push_cell(head_in),
    .pop(head_pop), .pop_cell(deq_cell),
    .count(head_cnt), .full(head_full), .empty(head_empty)
  );

  initial begin
    if (BUF_CELLS < 2 * BURST) $error("BUF_CELLS must be at least twice BURST");
  end

  p_reset_flags_r1: assert property (@(posedge clk)
    rst |=> (enq_ready && !deq_valid));
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_cell)));
  p_one_source_r2: assert property (@(posedge clk) disable iff (rst)
    !(bypass && bk_rd_vld));
  p_no_bypass_busy_r2: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !(bk_wr_beat || bk_rd_vld));
endmodule

// File: tb/cell_bulk_fifo_test.sv
module cell_bulk_fifo_test;
  localparam int CAP = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [15:0] enq_cell = '0;
  logic        deq_valid;
  logic        deq_ready = 1'b0;
  logic [15:0] deq_cell;

  int errors = 0;
  int checks = 0;
  int send_seq = 0;
  int recv_seq = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cell_bulk_fifo uut (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_cell(enq_cell),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_cell(deq_cell)
  );

  // {cell count, consumer pattern}
  localparam logic [15:0] VECS [6] = '{
    16'h1400, 16'h2801, 16'h3c02, 16'h2003, 16'h5004, 16'h0b01
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at negedge, detect the handshakes the coming rising edge will make.
  task automatic cycle(input logic ev, input logic dr);
    @(negedge clk);
    enq_valid = ev;
    enq_cell  = send_seq[15:0];
    deq_ready = dr;
    #1;
    if (ev && enq_ready) send_seq++;
    if (dr && deq_valid) begin
      check(deq_cell == recv_seq[15:0], "R2 order", int'(deq_cell), recv_seq & 16'hffff);
      recv_seq++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enq_valid = 1'b0; deq_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    recv_seq = send_seq;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(enq_ready == 1'b1, "R1 ready after reset", enq_ready, 1);
    check(deq_valid == 1'b0, "R1 empty after reset", deq_valid, 0);

    // R5: bypass latency into an empty block
    @(negedge clk);
    enq_valid = 1'b1; enq_cell = send_seq[15:0];
    @(negedge clk);
    enq_valid = 1'b0; send_seq++;
    check(deq_valid == 1'b0, "R5 not yet offered", deq_valid, 0);
    @(negedge clk);
    check(deq_valid == 1'b1, "R5 offered next edge", deq_valid, 1);
    check(deq_cell == recv_seq[15:0], "R5 cell value", int'(deq_cell), recv_seq & 16'hffff);
    cycle(1'b0, 1'b1);
    @(negedge clk);
    check(deq_valid == 1'b0, "R3 empty after single", deq_valid, 0);

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      int n, pat, cyc, target;
      n = int'(VECS[v][15:8]);
      pat = int'(VECS[v][7:0]);
      target = send_seq + n;
      cyc = 0;
      while (recv_seq < target && cyc < 3000) begin
        logic ev, dr;
        ev = (send_seq < target) && (pat != 3 || (cyc % 3) == 0);
        case (pat)
          1: dr = cyc[0];
          2: dr = (cyc >= 60);
          4: dr = ((cyc % 5) == 0);
          default: dr = 1'b1;
        endcase
        cycle(ev, dr);
        cyc++;
      end
      check(recv_seq == target, "R2 all cells out", recv_seq, target);
      @(negedge clk);
      deq_ready = 1'b0;
      check(deq_valid == 1'b0, "R3 empty after drain", deq_valid, 0);
    end

    // Full capacity with a stalled consumer (R4, R7, R8)
    begin
      int base, low_run, cyc;
      logic [15:0] first;
      do_reset();
      base = send_seq;
      low_run = 0; cyc = 0;
      while (low_run < 40 && cyc < 600) begin
        cycle(1'b1, 1'b0);
        if (!enq_ready) low_run++; else low_run = 0;
        if (cyc == 3) first = deq_cell;
        cyc++;
      end
      check(send_seq - base == CAP, "R4 accepted count", send_seq - base, CAP);
      check(enq_ready == 1'b0, "R4 ready held low", enq_ready, 0);
      check(deq_cell == first, "R7 head held while stalled", int'(deq_cell), int'(first));
      check(deq_valid == 1'b1, "R7 valid held while stalled", deq_valid, 1);
      cyc = 0;
      while (recv_seq < send_seq && cyc < 1000) begin
        cycle(1'b0, 1'b1);
        cyc++;
      end
      check(recv_seq == base + CAP, "R8 drained count", recv_seq - base, CAP);
      check(cyc <= 150, "R6 burst drain time", cyc, 150);
      low_run = 0;
      for (int k = 0; k < 30; k++) begin
        cycle(1'b0, 1'b1);
        if (deq_valid) low_run++;
      end
      check(low_run == 0 && recv_seq == base + CAP, "R8 no extra cell", low_run, 0);
    end

    // Reset in the middle of traffic discards stored cells (R1)
    for (int k = 0; k < 12; k++) cycle(1'b1, 1'b0);
    do_reset();
    @(negedge clk);
    check(deq_valid == 1'b0, "R1 cells discarded", deq_valid, 0);
    check(enq_ready == 1'b1, "R1 ready after mid reset", enq_ready, 1);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    @(negedge clk);
    check(deq_valid == 1'b1 && deq_cell == recv_seq[15:0], "R1 first cell after reset",
          int'(deq_cell), recv_seq & 16'hffff);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule